// File: doc/BRIEF.md
# Software-Triggered Peripheral Reset Pulser

This block lets software reset individual peripherals through a small register interface with two windows. The selection window holds a mask with one bit for each peripheral reset line. The trigger window holds a pulse-length field and a start bit. Software first writes the mask of lines to reset. It then writes the trigger with the start bit set. The block drives the chosen reset outputs high for a counted number of clock cycles, then releases them.

The start bit doubles as a busy flag. It reads as 1 for the whole pulse and drops on its own when the outputs release, so a driver can simply poll it. The mask and the pulse length are captured at the moment of the start. Any bus write that arrives while a pulse runs is dropped.

The longest pulse (field 0xFFFF) is 65539 cycles. At any clock above about 6.6 MHz this finishes well inside a 10 ms polling budget.

Top module: `rst_pulser`

## Requirements
- R1: After the block's reset (active-low `rstN`), every reset output is low, and both windows read 0: no selection, busy clear, pulse-length field 0. Asserting `rstN` during a pulse releases the outputs at once.
- R2: The selection window (`busWin`=0) keeps only bits 16..22, 25 and 31, which map to `rstOut[0]`..`rstOut[8]` in that order. Every other bit reads as 0, so writing 0xFFFFFFFF reads back 0x827F0000.
- R3: In the trigger window (`busWin`=1), bit 0 is start/busy and bits 31:16 hold the pulse-length field. Bits 15:1 read as 0. An idle write with bit 0 clear updates the field and starts nothing.
- R4: An idle trigger write with bit 0 set drives the selected outputs high starting with the clock edge that takes the write. They stay high for exactly field+4 cycles.
- R5: The busy bit reads 1 from the launch edge until the edge on which the outputs go low, and it clears on that same edge. Busy rises only after a trigger write with bit 0 set.
- R6: A pulse-length field of 0 is legal and gives a 4-cycle pulse.
- R7: Only the lines selected at launch time are pulsed. An all-zero selection still runs a busy period but drives no output.
- R8: While busy, writes to either window are ignored, and neither register changes.
- R9: Every output is driven by a register. Outputs stay steady for the whole pulse and are all low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| busValid | input | 1 | Bus access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write access |
| busWin | input | 1 | Window select: 0 = selection, 1 = trigger |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Current contents of the window chosen by `busWin` |
| rstOut | output | 9 | Active-high peripheral reset lines |

## Verification
The bench goes after the pulse-length boundary at field 0. An off-by-one counter would give a 3- or 5-cycle pulse there, or a pulse that never ends. It rewrites both windows in the middle of a pulse. A design that did not block writes would then lengthen the pulse, switch lines partway through, or leave a corrupted selection behind. It also launches with an empty mask and with unmapped mask bits set, which would expose outputs taken from the wrong bit positions. Finally, it pulls reset in the middle of a pulse to catch outputs that stay stuck high.

// File: rtl/rst_pulse_pkg.sv
package rst_pulse_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_LINES = 9;

  // register bit feeding each reset output, output index order
  localparam int LINE_POS [NUM_LINES] = '{16, 17, 18, 19, 20, 21, 22, 25, 31};

  function automatic logic [DATA_W-1:0] mappedMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LINES; i++) m[LINE_POS[i]] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] MAP_MASK = mappedMask();

  typedef struct packed {
    logic selWrite;
    logic delayWrite;
    logic launch;
    logic finish;
  } strobes_t;
endpackage

// File: rtl/rp_ctrl.sv
module rp_ctrl
  import rst_pulse_pkg::*;
#(
  parameter int DELAY_W   = 16,
  parameter int MIN_PULSE = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic               busWin,
  input  logic               startBit,
  input  logic [DELAY_W-1:0] delayIn,
  output strobes_t           stb,
  output logic               busy
);
  localparam int CNT_W = DELAY_W + $clog2(MIN_PULSE) + 1;

  logic [CNT_W-1:0] remain;
  logic             wrOk;

  always_comb begin
    wrOk           = busValid && busWrite && !busy;
    stb.selWrite   = wrOk && !busWin;
    stb.delayWrite = wrOk && busWin;
    stb.launch     = wrOk && busWin && startBit;
    stb.finish     = busy && (remain == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (stb.launch) begin
      busy   <= 1'b1;
      remain <= CNT_W'(delayIn) + CNT_W'(MIN_PULSE - 1);
    end else if (stb.finish) begin
      busy   <= 1'b0;
    end else if (busy) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/rp_datapath.sv
module rp_datapath
  import rst_pulse_pkg::*;
#(
  parameter int DELAY_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             stb,
  input  logic                 busy,
  input  logic                 busWin,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [DELAY_W-1:0]   delayIn,
  output logic [DATA_W-1:0]    busRdata,
  output logic [NUM_LINES-1:0] rstOut
);
  localparam int PAD_W = DATA_W - DELAY_W - 1;

  logic [DATA_W-1:0]  selQ;
  logic [DELAY_W-1:0] delayQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= '0;
      delayQ <= '0;
    end else begin
      if (stb.selWrite)   selQ   <= busWdata & MAP_MASK;
      if (stb.delayWrite) delayQ <= delayIn;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            rstOut[i] <= 1'b0;
      else if (stb.launch)  rstOut[i] <= selQ[LINE_POS[i]];
      else if (stb.finish)  rstOut[i] <= 1'b0;
    end
  end

  always_comb begin
    if (busWin) busRdata = {delayQ, {PAD_W{1'b0}}, busy};
    else        busRdata = selQ;
  end
endmodule

// File: rtl/rst_pulser.sv
module rst_pulser
  import rst_pulse_pkg::*;
#(
  parameter int DELAY_W   = 16,
  parameter int MIN_PULSE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic        busWin,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic [8:0]  rstOut
);
  strobes_t           stb;
  logic               busy;
  logic [DELAY_W-1:0] delayIn;

  assign delayIn = busWdata[DATA_W-1 -: DELAY_W];

  rp_ctrl #(.DELAY_W(DELAY_W), .MIN_PULSE(MIN_PULSE)) i_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busWin(busWin), .startBit(busWdata[0]), .delayIn(delayIn),
    .stb(stb), .busy(busy)
  );

  rp_datapath #(.DELAY_W(DELAY_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .busWin(busWin),
    .busWdata(busWdata), .delayIn(delayIn), .busRdata(busRdata),
    .rstOut(rstOut)
  );
endmodule

// File: rtl/rst_pulser_chk.sv
module rst_pulser_chk
  import rst_pulse_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic        busWin,
  input logic        startBit,
  input logic [31:0] busRdata,
  input logic [8:0]  rstOut,
  input logic        busy
);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> rstOut == '0);

  assert_pulse_steady_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(rstOut));

  assert_start_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(busValid && busWrite && busWin && startBit));

  assert_busy_readback_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy && busWin |-> busRdata[0]);

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busWin |-> (busRdata & ~MAP_MASK) == '0);

  assert_sel_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && !busWin && $past(!busWin) |-> $stable(busRdata));
endmodule

bind rst_pulser rst_pulser_chk i_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busWin(busWin), .startBit(busWdata[0]), .busRdata(busRdata),
  .rstOut(rstOut), .busy(busy)
);

// File: tb/test_rst_pulser.sv
module test_rst_pulser;
  localparam int POS [9] = '{16, 17, 18, 19, 20, 21, 22, 25, 31};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic        busWin = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [8:0]  rstOut;

  int compared = 0;
  int mismatched = 0;
  bit armed = 0;

  // behavioural reference
  logic [31:0] mSel = '0;
  logic [15:0] mDelay = '0;
  logic        mBusy = 1'b0;
  int          mRemain = 0;
  logic [8:0]  mLines = '0;

  rst_pulser i_rst_pulser (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busWin(busWin), .busWdata(busWdata), .busRdata(busRdata), .rstOut(rstOut)
  );

  always #2 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSel = '0; mDelay = '0; mBusy = 0; mRemain = 0; mLines = '0;
    end else if (mBusy) begin
      if (mRemain == 0) begin mBusy = 0; mLines = '0; end
      else mRemain--;
    end else if (busValid && busWrite) begin
      if (!busWin) begin
        mSel = '0;
        for (int i = 0; i < 9; i++) mSel[POS[i]] = busWdata[POS[i]];
      end else begin
        mDelay = busWdata[31:16];
        if (busWdata[0]) begin
          mBusy = 1; mRemain = int'(mDelay) + 3;
          for (int i = 0; i < 9; i++) mLines[i] = mSel[POS[i]];
        end
      end
    end
  end

  always @(negedge clk) if (armed && rstN) begin
    compared++;
    if (rstOut !== mLines) begin
      mismatched++;
      $display("FAIL R4 R7 R9 per-cycle rstOut actual=%h expected=%h t=%0t", rstOut, mLines, $time);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(logic win, logic [31:0] data);
    @(negedge clk);
    busValid = 1; busWrite = 1; busWin = win; busWdata = data;
    @(negedge clk);
    busValid = 0; busWrite = 0; busWdata = '0;
  endtask

  task automatic readNow(logic win, string tag, logic [31:0] exp);
    busWin = win; #1;
    check(tag, busRdata, exp);
  endtask

  task automatic waitIdle();
    while (mBusy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure(int line, output int width);
    width = 0;
    while (rstOut[line] && width < 70000) begin width++; @(negedge clk); end
  endtask

  int w;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    readNow(0, "R1 reset sel", 32'h0);
    readNow(1, "R1 reset trig", 32'h0);
    check("R1 reset outputs", 32'(rstOut), 32'h0);
    rstN = 1'b1;
    armed = 1;

    // R2 mapping
    busWr(0, 32'hFFFF_FFFF);
    readNow(0, "R2 unmapped bits read zero", 32'h827F_0000);

    // R3 field write without start
    busWr(1, 32'h0005_FFFE);
    readNow(1, "R3 field only, no start", 32'h0005_0000);
    check("R3 no pulse without start", 32'(rstOut), 32'h0);

    // R6 R4 zero field, single line (bit 18 -> line 2)
    busWr(0, 32'h0004_0000);
    busWr(1, 32'h0000_0001);
    readNow(1, "R5 busy reads 1", 32'h0000_0001);
    check("R4 line 2 only", 32'(rstOut), 32'h004);
    measure(2, w);
    check("R6 zero-field width", w, 4);
    readNow(1, "R5 busy self-clears", 32'h0000_0000);

    // R7 R8 multiple lines, writes during pulse
    busWr(0, 32'h8200_0001 | 32'h0001_0000);
    busWr(1, 32'h000A_0001);
    check("R7 lines 0,7,8", 32'(rstOut), 32'h181);
    busWr(0, 32'h0008_0000);
    busWr(1, 32'h00FF_0001);
    check("R8 lines unchanged by busy writes", 32'(rstOut), 32'h181);
    waitIdle();
    readNow(0, "R8 sel kept", 32'h8201_0000);
    readNow(1, "R8 field kept", 32'h000A_0000);

    // R7 empty selection
    busWr(0, 32'h0000_FFFF);
    readNow(0, "R2 low bits dropped", 32'h0);
    busWr(1, 32'h0002_0001);
    readNow(1, "R7 busy with empty mask", 32'h0002_0001);
    check("R7 empty mask no output", 32'(rstOut), 32'h0);
    waitIdle();

    // R4 long pulse, bit 21 -> line 5
    busWr(0, 32'h0020_0000);
    busWr(1, 32'h03E8_0001);
    measure(5, w);
    check("R4 width field 1000", w, 1004);
    waitIdle();

    // R1 reset mid-pulse
    busWr(0, 32'h8000_0000);
    busWr(1, 32'h0032_0001);
    repeat (5) @(negedge clk);
    check("R7 line 8 active", 32'(rstOut), 32'h100);
    #1 rstN = 1'b0;
    #1 check("R1 async release", 32'(rstOut), 32'h0);
    @(negedge clk);
    readNow(0, "R1 sel cleared", 32'h0);
    readNow(1, "R1 trig cleared", 32'h0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule